// File: doc/BRIEF.md
# Virtual-8086 Interrupt-Return Privilege and Flag Filter

This block settles the outcome of an interrupt return that runs while the processor is in virtual-8086 mode. The execution pipeline gives it the operand size of the return, the current flags register, the flag image and instruction pointer that the return pops, the number of stack bytes available, and whether the virtual-interrupt extension is on. One cycle later the block reports one of three outcomes: a general-protection fault, a stack fault, or a successful return. A successful return carries the merged flags value, its write enable, the new instruction pointer and the number of bytes to pop.

The set of flags the return may change depends on the operand size and on the extension. When the extension handles a 16-bit return at an I/O privilege level below 3, the popped interrupt-enable bit goes into the virtual interrupt flag. The real interrupt-enable bit and the I/O privilege level are left as they were. Loading the code segment and all memory traffic are handled outside this block.

Top module: `v86_iret_filter`

## Requirements
- R1: While reset is held and in the cycle after reset, rsp_valid, fault_gp, fault_ss and flags_we are 0, and pop_bytes, flags_next and ip_next are 0.
- R2: A 16-bit return (req_op32=0) with IOPL (cur_flags[13:12]) below 3 and vme_en=0 raises fault_gp. This holds whatever the stack room is.
- R3: A 32-bit return (req_op32=1) with IOPL below 3 raises fault_gp for either value of vme_en. This holds whatever the stack room is.
- R4: If no privilege fault applies, a 16-bit return with stack_room below 6, or a 32-bit return with stack_room below 12, raises fault_ss. Exactly 6 or 12 bytes is enough. A stack fault takes precedence over the check in R5.
- R5: For a 16-bit return with vme_en=1 and IOPL below 3, fault_gp is raised in two cases: the popped TF (bit 8) is set, or the popped IF (bit 9) is set while the current VIP (bit 20) is set. A popped IF with VIP clear does not fault.
- R6: When R5 applies and no fault occurs, the block writes only CF(0), PF(2), AF(4), ZF(6), SF(7), TF(8), DF(10), OF(11), NT(14) and VIF(19). VIF takes the popped IF, and every other bit keeps its current value, IF and IOPL included.
- R7: A successful 32-bit return writes CF, PF, AF, ZF, SF, TF, IF(9), DF, OF, NT, RF(16), AC(18) and ID(21) from the popped image. IOPL, VM(17), VIF and VIP keep their current values.
- R8: A successful 16-bit return at IOPL 3 writes CF, PF, AF, ZF, SF, TF, IF, DF, OF and NT from the popped image. IOPL and all bits above 15 keep their current values. This applies whatever vme_en is.
- R9: On success, ip_next is the popped 16-bit IP zero-extended (16-bit) or the full popped EIP (32-bit), and pop_bytes is 6 or 12 respectively.
- R10: When a fault is reported, flags_we is 0, pop_bytes and ip_next are 0, and flags_next equals the current flags.
- R11: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and at most one of fault_gp and fault_ss is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A return is being evaluated this cycle |
| req_op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| vme_en | input | 1 | Virtual-interrupt extension enabled |
| cur_flags | input | 32 | Current flags register |
| pop_flags | input | 32 | Flag image popped by the return |
| pop_ip | input | 32 | Instruction pointer popped by the return |
| stack_room | input | ROOM_W | Stack bytes available for popping |
| rsp_valid | output | 1 | Result valid |
| fault_gp | output | 1 | General-protection fault, error code 0 |
| fault_ss | output | 1 | Stack fault, error code 0 |
| flags_we | output | 1 | Write flags_next into the flags register |
| pop_bytes | output | 4 | Bytes to pop on success |
| flags_next | output | 32 | Merged flags value |
| ip_next | output | 32 | New instruction pointer |

## Verification
The bench probes the order in which faults are checked. A privilege fault must win over a stack that is too small, and a stack fault must win over a popped TF on the extension path. A design with either order reversed reports the wrong fault kind. The bench uses stack room at exactly 6 and 12 bytes and one byte short of each, which exposes an off-by-one compare. It also feeds all-ones images on every path. A design that used the wrong write mask would change IOPL, VM or VIP, or would fail to move the popped IF into VIF while keeping the real IF.

// File: rtl/v86_iret_pkg.sv
package v86_iret_pkg;

    localparam int FLAG_W = 32;

    localparam int BIT_TF  = 8;
    localparam int BIT_IF  = 9;
    localparam int BIT_VIF = 19;
    localparam int BIT_VIP = 20;
    localparam int IOPL_LO = 12;

    // arithmetic group: CF PF AF ZF SF OF
    localparam logic [FLAG_W-1:0] MASK_ARITH = 32'h0000_08D5;
    localparam logic [FLAG_W-1:0] MASK_TF    = 32'h0000_0100;
    localparam logic [FLAG_W-1:0] MASK_IF    = 32'h0000_0200;
    localparam logic [FLAG_W-1:0] MASK_DF    = 32'h0000_0400;
    localparam logic [FLAG_W-1:0] MASK_NT    = 32'h0000_4000;
    localparam logic [FLAG_W-1:0] MASK_RF    = 32'h0001_0000;
    localparam logic [FLAG_W-1:0] MASK_AC    = 32'h0004_0000;
    localparam logic [FLAG_W-1:0] MASK_VIF   = 32'h0008_0000;
    localparam logic [FLAG_W-1:0] MASK_ID    = 32'h0020_0000;

    localparam logic [FLAG_W-1:0] WMASK_16 =
        MASK_ARITH | MASK_TF | MASK_IF | MASK_DF | MASK_NT;
    localparam logic [FLAG_W-1:0] WMASK_16_VIRT =
        MASK_ARITH | MASK_TF | MASK_DF | MASK_NT | MASK_VIF;
    localparam logic [FLAG_W-1:0] WMASK_32 =
        WMASK_16 | MASK_RF | MASK_AC | MASK_ID;

    localparam int BYTES_16 = 6;
    localparam int BYTES_32 = 12;

    typedef struct packed {
        logic              done;
        logic              gp;
        logic              ss;
        logic              we;
        logic [3:0]        bytes;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] ip;
    } iret_res_t;

endpackage

// File: rtl/v86_iret_check.sv
module v86_iret_check
    import v86_iret_pkg::*;
#(
    parameter int ROOM_W = 8
) (
    input  logic              is_op32,
    input  logic              virt_en,
    input  logic [1:0]        iopl,
    input  logic              cur_vip,
    input  logic              img_tf,
    input  logic              img_if,
    input  logic [ROOM_W-1:0] room,
    output logic              gp_fault,
    output logic              ss_fault,
    output logic              virt_path
);
    localparam logic [ROOM_W-1:0] NEED_16 = ROOM_W'(BYTES_16);
    localparam logic [ROOM_W-1:0] NEED_32 = ROOM_W'(BYTES_32);

    logic low_priv;
    logic gp_priv;
    logic gp_virt;
    logic short_stack;

    always_comb begin
        low_priv    = (iopl != 2'b11);
        gp_priv     = low_priv && (is_op32 || !virt_en);
        short_stack = is_op32 ? (room < NEED_32) : (room < NEED_16);
        ss_fault    = !gp_priv && short_stack;
        virt_path   = !is_op32 && virt_en && low_priv;
        gp_virt     = virt_path && !short_stack && (img_tf || (img_if && cur_vip));
        gp_fault    = gp_priv || gp_virt;
    end
endmodule

// File: rtl/v86_iret_merge.sv
module v86_iret_merge
    import v86_iret_pkg::*;
(
    input  logic              is_op32,
    input  logic              virt_path,
    input  logic [FLAG_W-1:0] cur,
    input  logic [FLAG_W-1:0] img,
    output logic [FLAG_W-1:0] merged
);
    logic [FLAG_W-1:0] wmask;
    logic [FLAG_W-1:0] src;

    always_comb begin
        if (is_op32) begin
            wmask = WMASK_32;
            src   = img;
        end else if (virt_path) begin
            wmask        = WMASK_16_VIRT;
            src          = {16'b0, img[15:0]};
            src[BIT_VIF] = img[BIT_IF];
        end else begin
            wmask = WMASK_16;
            src   = {16'b0, img[15:0]};
        end
    end

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        assign merged[b] = wmask[b] ? src[b] : cur[b];
    end
endmodule

// File: rtl/v86_iret_filter.sv
module v86_iret_filter
    import v86_iret_pkg::*;
#(
    parameter int ROOM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op32,
    input  logic              vme_en,
    input  logic [31:0]       cur_flags,
    input  logic [31:0]       pop_flags,
    input  logic [31:0]       pop_ip,
    input  logic [ROOM_W-1:0] stack_room,
    output logic              rsp_valid,
    output logic              fault_gp,
    output logic              fault_ss,
    output logic              flags_we,
    output logic [3:0]        pop_bytes,
    output logic [31:0]       flags_next,
    output logic [31:0]       ip_next
);
    logic              gp_w, ss_w, virt_w;
    logic [FLAG_W-1:0] merged_w;
    iret_res_t         res_d, res_q;

    v86_iret_check #(.ROOM_W(ROOM_W)) u_check (
        .is_op32   (req_op32),
        .virt_en   (vme_en),
        .iopl      (cur_flags[IOPL_LO+1:IOPL_LO]),
        .cur_vip   (cur_flags[BIT_VIP]),
        .img_tf    (pop_flags[BIT_TF]),
        .img_if    (pop_flags[BIT_IF]),
        .room      (stack_room),
        .gp_fault  (gp_w),
        .ss_fault  (ss_w),
        .virt_path (virt_w)
    );

    v86_iret_merge u_merge (
        .is_op32   (req_op32),
        .virt_path (virt_w),
        .cur       (cur_flags),
        .img       (pop_flags),
        .merged    (merged_w)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.done = 1'b1;
            if (gp_w || ss_w) begin
                res_d.gp    = gp_w;
                res_d.ss    = ss_w;
                res_d.flags = cur_flags;
            end else begin
                res_d.we    = 1'b1;
                res_d.bytes = req_op32 ? 4'(BYTES_32) : 4'(BYTES_16);
                res_d.flags = merged_w;
                res_d.ip    = req_op32 ? pop_ip : {16'b0, pop_ip[15:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rsp_valid  = res_q.done;
    assign fault_gp   = res_q.gp;
    assign fault_ss   = res_q.ss;
    assign flags_we   = res_q.we;
    assign pop_bytes  = res_q.bytes;
    assign flags_next = res_q.flags;
    assign ip_next    = res_q.ip;

    a_r11_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_gp, fault_ss}));

    a_r10_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ss) |-> (!flags_we && pop_bytes == 4'd0));

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6 R7 R8: IOPL is never altered by a return in this mode
    a_r6_iopl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!flags_we || flags_next[13:12] == $past(cur_flags[13:12])));

    // R7: VM and VIP are never written
    a_r7_vm_vip_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!flags_we ||
            (flags_next[17] == $past(cur_flags[17]) &&
             flags_next[20] == $past(cur_flags[20]))));

    a_r9_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (pop_bytes == 4'd6 || pop_bytes == 4'd12));
endmodule

// File: tb/sim_v86_iret_filter.sv
`timescale 1ns/1ps
module sim_v86_iret_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op32 = 1'b0, vme_en = 1'b0;
    logic [31:0] cur_flags = '0, pop_flags = '0, pop_ip = '0;
    logic [7:0]  stack_room = '0;
    logic        rsp_valid, fault_gp, fault_ss, flags_we;
    logic [3:0]  pop_bytes;
    logic [31:0] flags_next, ip_next;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    v86_iret_filter #(.ROOM_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op32(req_op32),
        .vme_en(vme_en), .cur_flags(cur_flags), .pop_flags(pop_flags),
        .pop_ip(pop_ip), .stack_room(stack_room), .rsp_valid(rsp_valid),
        .fault_gp(fault_gp), .fault_ss(fault_ss), .flags_we(flags_we),
        .pop_bytes(pop_bytes), .flags_next(flags_next), .ip_next(ip_next)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic        op32;
        logic        vme;
        logic [31:0] cur;
        logic [31:0] pop;
        logic [31:0] ip;
        logic [7:0]  room;
        logic        gp;
        logic        ss;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R2: 16-bit, IOPL 0, extension off
        '{4'd2, 1'b0, 1'b0, 32'h0002_0002, 32'h0000_FFFF, 32'h0000_1111, 8'd20, 1'b1, 1'b0},
        // R8: 16-bit, IOPL 3, exact room 6
        '{4'd8, 1'b0, 1'b0, 32'h0002_3002, 32'hFFFF_CFFF, 32'h0000_2222, 8'd6,  1'b0, 1'b0},
        // R4: 16-bit, IOPL 3, room 5
        '{4'd4, 1'b0, 1'b0, 32'h0002_3002, 32'h0000_0000, 32'h0000_0000, 8'd5,  1'b0, 1'b1},
        // R3: 32-bit, IOPL 2, extension on
        '{4'd3, 1'b1, 1'b1, 32'h0002_2002, 32'h0000_0000, 32'h0000_0000, 8'd40, 1'b1, 1'b0},
        // R4: 32-bit, IOPL 3, room 11
        '{4'd4, 1'b1, 1'b0, 32'h0002_3002, 32'h0000_0000, 32'h0000_0000, 8'd11, 1'b0, 1'b1},
        // R7: 32-bit, IOPL 3, room 12, all-ones image
        '{4'd7, 1'b1, 1'b0, 32'h0012_3002, 32'hFFFF_FFFF, 32'h1234_5678, 8'd12, 1'b0, 1'b0},
        // R7: 32-bit clearing image
        '{4'd7, 1'b1, 1'b1, 32'h003F_7FD7, 32'h0000_0002, 32'h8000_0001, 8'd12, 1'b0, 1'b0},
        // R5: extension path, popped TF
        '{4'd5, 1'b0, 1'b1, 32'h0002_0002, 32'h0000_0100, 32'h0000_0000, 8'd6,  1'b1, 1'b0},
        // R5: popped IF while VIP set
        '{4'd5, 1'b0, 1'b1, 32'h0012_1002, 32'h0000_0200, 32'h0000_0000, 8'd6,  1'b1, 1'b0},
        // R6: popped IF, VIP clear -> VIF set, IF kept 0
        '{4'd6, 1'b0, 1'b1, 32'h0002_1002, 32'h0000_0200, 32'hABCD_1234, 8'd6,  1'b0, 1'b0},
        // R6: clear VIF, IF stays 1
        '{4'd6, 1'b0, 1'b1, 32'h000A_0202, 32'h0000_4CD5, 32'h0000_5555, 8'd9,  1'b0, 1'b0},
        // R4: stack fault wins over popped TF on extension path
        '{4'd4, 1'b0, 1'b1, 32'h0002_0002, 32'h0000_0100, 32'h0000_0000, 8'd5,  1'b0, 1'b1},
        // R3: privilege fault wins over empty stack
        '{4'd3, 1'b1, 1'b0, 32'h0002_0002, 32'h0000_0000, 32'h0000_0000, 8'd0,  1'b1, 1'b0},
        // R8: IOPL 3 with extension on uses plain path; TF and IF taken
        '{4'd8, 1'b0, 1'b1, 32'h0012_3002, 32'h0000_0300, 32'h0000_7777, 8'd6,  1'b0, 1'b0}
    };

    // independent model of the write rules in R6, R7, R8
    function automatic logic [31:0] exp_flags(logic op32, logic vme,
                                              logic [31:0] cur, logic [31:0] pop);
        logic [31:0] m, s;
        if (op32) begin
            m = 32'h0025_4FD5; s = pop;
        end else if (vme && cur[13:12] != 2'b11) begin
            m = 32'h0008_4DD5; s = {16'b0, pop[15:0]}; s[19] = pop[9];
        end else begin
            m = 32'h0000_4FD5; s = {16'b0, pop[15:0]};
        end
        return (cur & ~m) | (s & m);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic op32, logic vme, logic [31:0] cur,
                         logic [31:0] pop, logic [31:0] ip, logic [7:0] room);
        @(negedge clk);
        req_valid = 1'b1; req_op32 = op32; vme_en = vme;
        cur_flags = cur; pop_flags = pop; pop_ip = ip; stack_room = room;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 faults", {30'b0, fault_gp, fault_ss}, 0);
        chk("R1 we/bytes", {27'b0, flags_we, pop_bytes}, 0);
        chk("R1 flags_next", flags_next, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {28'b0, rsp_valid, fault_gp, fault_ss, flags_we}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            logic ok;
            v = VECS[i];
            tg = $sformatf("R%0d vec%0d", v.tag, i);
            issue(v.op32, v.vme, v.cur, v.pop, v.ip, v.room);
            ok = !(v.gp || v.ss);
            chk({tg, " valid (R11)"}, 32'(rsp_valid), 1);
            chk({tg, " gp"}, 32'(fault_gp), 32'(v.gp));
            chk({tg, " ss"}, 32'(fault_ss), 32'(v.ss));
            chk({tg, " we (R10)"}, 32'(flags_we), 32'(ok));
            chk({tg, " flags"}, flags_next,
                ok ? exp_flags(v.op32, v.vme, v.cur, v.pop) : v.cur);
            // R9: ip and byte count
            chk({tg, " ip (R9)"}, ip_next,
                !ok ? 32'h0 : (v.op32 ? v.ip : {16'b0, v.ip[15:0]}));
            chk({tg, " bytes (R9)"}, 32'(pop_bytes),
                !ok ? 32'd0 : (v.op32 ? 32'd12 : 32'd6));
        end

        // R6: literal check, VIF from popped IF, IF and IOPL kept
        issue(1'b0, 1'b1, 32'h0002_1002, 32'h0000_F2FF, 32'h0, 8'd6);
        chk("R6 literal", flags_next, 32'h000A_50D7);
        // R7: literal all-ones image keeps VIP, VM, IOPL, VIF
        issue(1'b1, 1'b0, 32'h0012_3002, 32'hFFFF_FFFF, 32'h0, 8'd12);
        chk("R7 literal", flags_next, 32'h0037_7FD7);

        // R11: response lasts one cycle when no new request
        @(negedge clk);
        chk("R11 idle", 32'(rsp_valid), 0);

        // R1: reset mid-stream clears outputs
        issue(1'b1, 1'b0, 32'h0002_3002, 32'h0, 32'h0, 8'd12);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", {28'b0, rsp_valid, fault_gp, fault_ss, flags_we}, 0);
        rst_n = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule